// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 32 interrupt lines and presents them to a processor on two active-low request pins: a normal request and a fast request. Line 0 is always the fast source. Lines 1 to 31 are normal sources. Each normal source has a 3-bit priority, a level-or-edge selection and a 32-bit vector word. An arbiter picks the most urgent pending source. The normal request is driven only while that winner's priority is strictly above the level currently in service. A stack of the priorities being served lets a more urgent source interrupt the handler of a less urgent one.

Software works through a word-addressed register bus. A read strobe returns data in the same cycle, and any side effect of a strobe takes place at the following clock edge. When the handler reads the vector register, the controller commits that source: it pushes its priority onto the nesting stack and clears an edge source's latch. An end-of-interrupt write pops the stack. In protect mode, reads have no side effects, so a debugger can inspect the vector register safely, and the commit moves to a write of the vector register. A force mask moves any normal source onto the fast pin. All pins are plain control and status signals, so there is no stream handshake and no back-pressure.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, nirq_o and nfiq_o are high. The enable register (address 67) reads 0 and the pending register (address 72) reads 0.
- R2: Address n (0 to 31) configures source n: bits [2:0] hold the priority (7 is the most urgent) and bit 7 selects edge mode. A level source is pending while its input is high. An edge source latches a rising edge. A write to address 73 clears the latched bits set to 1 in the write data.
- R3: nirq_o is low exactly when an enabled, non-forced source among 1 to 31 is pending with a priority above the current level. When nothing is in service, any such source counts.
- R4: A read of the vector register (address 64) returns the word stored at address 32+n for the winning source n. The winner is the most urgent source, and on equal priority the lower source number wins.
- R5: A read of address 64 while no source qualifies under R3 returns the spurious word (address 69) and has no side effect.
- R6: Outside protect mode, a qualifying read of address 64 makes the winner's priority the current level and clears the winner's edge latch. After that, sources of equal or lower priority do not drive nirq_o.
- R7: A write to address 68 (end of interrupt) restores the level that was current before the latest commit. When nothing is in service, the write is ignored.
- R8: Commits nest eight deep, one for each priority level, in ascending order of priority.
- R9: When bit 0 of address 70 (protect) is set, reads of address 64 leave the level unchanged. A write to address 64 then performs the commit of R6.
- R10: nfiq_o is low while enabled source 0, or an enabled source whose bit is set in the force mask (address 71), is pending. Forced sources take no part in the nirq_o arbitration.
- R11: A write to address 65 sets enable bits and a write to address 66 clears them. Address 67 reads the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| src_i | input | 32 | Interrupt source lines |
| nirq_o | output | 1 | Normal interrupt request, active low |
| nfiq_o | output | 1 | Fast interrupt request, active low |

## Verification
The bench builds the controller with its defaults: 32 sources and a 3-bit priority, which gives eight levels and a stack eight entries deep. These values let a directed sequence fill every level of the stack and then unwind it one entry at a time. They also let random priority and enable patterns across all 31 normal lines produce ties, spurious reads and nesting of uneven depth, which a reference model scores.

// File: rtl/irqn_pkg.sv
`timescale 1ns/1ps
package irqn_pkg;
  // word addresses on the register bus
  localparam int unsigned A_CFG_BASE = 0;   // 0..31   per-source config
  localparam int unsigned A_VEC_BASE = 32;  // 32..63  per-source vector
  localparam int unsigned A_VECTOR   = 64;
  localparam int unsigned A_EN_SET   = 65;
  localparam int unsigned A_EN_CLR   = 66;
  localparam int unsigned A_EN       = 67;
  localparam int unsigned A_EOI      = 68;
  localparam int unsigned A_SPUR     = 69;
  localparam int unsigned A_CTRL     = 70;
  localparam int unsigned A_FORCE    = 71;
  localparam int unsigned A_PEND     = 72;
  localparam int unsigned A_CLR      = 73;
  localparam int unsigned EDGE_BIT   = 7;
endpackage

// File: rtl/irqn_src_bank.sv
`timescale 1ns/1ps
module irqn_src_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] edge_sel,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic q, prev, lat;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q    <= 1'b0;
        prev <= 1'b0;
        lat  <= 1'b0;
      end else begin
        q    <= src_i[g];
        prev <= q;
        if (q && !prev) lat <= 1'b1;
        else if (clr[g]) lat <= 1'b0;
      end
    end
    assign pend[g] = edge_sel[g] ? lat : q;

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lat && !clr[g] |=> lat) else $error("edge latch lost"); // R2
  end
endmodule

// File: rtl/irqn_arbiter.sv
`timescale 1ns/1ps
module irqn_arbiter #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        cand,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    found,
  output logic [IDX_W-1:0]        idx,
  output logic [PRIO_W-1:0]       best
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    AST_NO_BETTER: assert property (@(posedge clk) disable iff (!rst_n)
      found && cand[g] |-> (prio_flat[g*PRIO_W +: PRIO_W] < best) ||
        (prio_flat[g*PRIO_W +: PRIO_W] == best && IDX_W'(g) >= idx))
      else $error("arbiter missed a better source"); // R4
  end
endmodule

// File: rtl/irqn_stack.sv
`timescale 1ns/1ps
module irqn_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_val,
  input  logic              pop,
  output logic              has_cur,
  output logic [PRIO_W-1:0] cur_prio,
  output logic [SP_W-1:0]   depth
);
  logic [PRIO_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]   sp, sp_m1;

  assign sp_m1 = sp - SP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push && sp < SP_W'(DEPTH)) begin
      stk[sp[IX_W-1:0]] <= push_val;
      sp <= sp + SP_W'(1);
    end else if (pop && sp != '0) begin
      sp <= sp_m1;
    end
  end

  assign has_cur  = (sp != '0);
  assign cur_prio = has_cur ? stk[sp_m1[IX_W-1:0]] : '0;
  assign depth    = sp;

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> sp < SP_W'(DEPTH)) else $error("stack overflow"); // R8
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && sp == '0 |=> sp == '0) else $error("pop on empty"); // R7
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl
  import irqn_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 7,
  localparam int DEPTH = 1 << PRIO_W,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  src_i,
  output logic              nirq_o,
  output logic              nfiq_o
);
  logic [PRIO_W-1:0] cfg_prio [N_SRC];
  logic [N_SRC-1:0]  cfg_edge, en_q, force_q, pend, cand, clr;
  logic [31:0]       vec_q [N_SRC];
  logic [31:0]       spur_q;
  logic              protect_q;
  logic [N_SRC*PRIO_W-1:0] prio_flat;

  logic              found, has_cur, irq_req, commit, pop;
  logic [IDX_W-1:0]  win;
  logic [PRIO_W-1:0] bprio, cur_prio;
  logic [SP_W-1:0]   depth;
  logic              at_vec;

  for (genvar g = 0; g < N_SRC; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_prio[g];
  end

  irqn_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .edge_sel(cfg_edge),
    .clr(clr), .pend(pend));

  // source 0 and forced sources never join the normal arbitration
  assign cand = pend & en_q & ~force_q & ~N_SRC'(1);

  irqn_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand(cand), .prio_flat(prio_flat),
    .found(found), .idx(win), .best(bprio));

  assign at_vec  = (bus_addr == ADDR_W'(A_VECTOR));
  assign irq_req = found && (!has_cur || bprio > cur_prio);
  assign commit  = irq_req && at_vec &&
                   ((bus_rd && !protect_q) || (bus_wr && protect_q));
  assign pop     = bus_wr && (bus_addr == ADDR_W'(A_EOI));
  assign clr     = (commit ? (N_SRC'(1) << win) : '0) |
                   ((bus_wr && bus_addr == ADDR_W'(A_CLR)) ? bus_wdata[N_SRC-1:0] : '0);

  irqn_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(commit), .push_val(bprio), .pop(pop),
    .has_cur(has_cur), .cur_prio(cur_prio), .depth(depth));

  assign nirq_o = !irq_req;
  assign nfiq_o = !(|(pend & en_q & (force_q | N_SRC'(1))));

  // per-source configuration and vector storage
  for (genvar g = 0; g < N_SRC; g++) begin : g_regs
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_prio[g] <= '0;
        cfg_edge[g] <= 1'b0;
        vec_q[g]    <= '0;
      end else if (bus_wr) begin
        if (bus_addr == ADDR_W'(A_CFG_BASE + g)) begin
          cfg_prio[g] <= bus_wdata[PRIO_W-1:0];
          cfg_edge[g] <= bus_wdata[EDGE_BIT];
        end
        if (bus_addr == ADDR_W'(A_VEC_BASE + g)) vec_q[g] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      force_q   <= '0;
      spur_q    <= '0;
      protect_q <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_W'(A_EN_SET): en_q      <= en_q | bus_wdata[N_SRC-1:0];
        ADDR_W'(A_EN_CLR): en_q      <= en_q & ~bus_wdata[N_SRC-1:0];
        ADDR_W'(A_SPUR):   spur_q    <= bus_wdata;
        ADDR_W'(A_CTRL):   protect_q <= bus_wdata[0];
        ADDR_W'(A_FORCE):  force_q   <= bus_wdata[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_addr == ADDR_W'(A_CFG_BASE + i)) begin
        bus_rdata[PRIO_W-1:0] = cfg_prio[i];
        bus_rdata[EDGE_BIT]   = cfg_edge[i];
      end
      if (bus_addr == ADDR_W'(A_VEC_BASE + i)) bus_rdata = vec_q[i];
    end
    case (bus_addr)
      ADDR_W'(A_VECTOR): bus_rdata = irq_req ? vec_q[win] : spur_q;
      ADDR_W'(A_EN):     bus_rdata = 32'(en_q);
      ADDR_W'(A_SPUR):   bus_rdata = spur_q;
      ADDR_W'(A_CTRL):   bus_rdata = {31'b0, protect_q};
      ADDR_W'(A_FORCE):  bus_rdata = 32'(force_q);
      ADDR_W'(A_PEND):   bus_rdata = 32'(pend);
      default: ;
    endcase
  end

  AST_COMMIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> has_cur && cur_prio == $past(bprio)) else $error("commit level"); // R6
  AST_PROTECT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && at_vec && protect_q && !bus_wr |=> $stable(depth)) else $error("protect push"); // R9
  AST_SPUR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && at_vec && nirq_o |-> bus_rdata == spur_q) else $error("spurious read"); // R5
  AST_FAST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] && en_q[0] |-> !nfiq_o) else $error("fast line"); // R10
endmodule

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  import irqn_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] src = '0;
  logic        nirq, nfiq;

  int total = 0, fails = 0;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .src_i(src),
    .nirq_o(nirq), .nfiq_o(nfiq));

  always #2 clk = ~clk;

  // reference model state
  int          m_prio [32];
  logic [31:0] m_vec  [32];
  logic [31:0] m_en, m_src;
  int          bstk [8];
  int          bsp;
  logic [31:0] spur_val = 32'hDEAD0001;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_w(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_r(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk);
    src = v;
  endtask

  function automatic int m_best();
    int b = -1;
    for (int i = 1; i < 32; i++)
      if (m_src[i] && m_en[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  function automatic bit m_req();
    int b = m_best();
    if (b < 0) return 1'b0;
    return (bsp == 0) || (m_prio[b] > bstk[bsp-1]);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 nirq", 32'(nirq), 32'd1);
    chk("R1 nfiq", 32'(nfiq), 32'd1);
    bus_r(A_EN, d);   chk("R1 enable", d, 32'd0);
    bus_r(A_PEND, d); chk("R1 pending", d, 32'd0);

    // R11 enable set / clear
    bus_w(A_EN_SET, 32'h28); bus_r(A_EN, d); chk("R11 set", d, 32'h28);
    bus_w(A_EN_CLR, 32'h08); bus_r(A_EN, d); chk("R11 clr", d, 32'h20);
    bus_w(A_EN_CLR, '1);

    // R5 spurious read
    bus_w(A_SPUR, spur_val);
    bus_r(A_VECTOR, d); chk("R5 spurious", d, spur_val);
    chk("R5 nirq", 32'(nirq), 32'd1);

    // R4 tie on equal priority -> lower number
    bus_w(A_CFG_BASE+4, 5); bus_w(A_CFG_BASE+9, 5);
    bus_w(A_VEC_BASE+4, 32'h400); bus_w(A_VEC_BASE+9, 32'h900);
    bus_w(A_EN_SET, 32'h210);
    set_src(32'h210); idle(3);
    chk("R3 request", 32'(nirq), 32'd0);
    bus_r(A_VECTOR, d); chk("R4 tie", d, 32'h400);
    chk("R6 equal masked", 32'(nirq), 32'd1);
    bus_w(A_EOI, 0); idle(1);
    chk("R7 restore", 32'(nirq), 32'd0);
    bus_r(A_VECTOR, d); chk("R4 tie again", d, 32'h400);
    bus_w(A_EOI, 0);
    set_src(0); bus_w(A_EN_CLR, '1); idle(2);

    // R2 / R6 edge source
    bus_w(A_CFG_BASE+7, 32'h82); bus_w(A_VEC_BASE+7, 32'h700);
    bus_w(A_EN_SET, 32'h80);
    set_src(32'h80); set_src(0); idle(3);
    bus_r(A_PEND, d); chk("R2 edge latched", d, 32'h80);
    chk("R3 edge req", 32'(nirq), 32'd0);
    bus_r(A_VECTOR, d); chk("R4 edge vec", d, 32'h700);
    bus_r(A_PEND, d); chk("R6 edge cleared", d, 32'h0);
    bus_w(A_EOI, 0); idle(1);
    chk("R6 no re-request", 32'(nirq), 32'd1);
    set_src(32'h80); set_src(0); idle(3);
    bus_r(A_PEND, d); chk("R2 edge again", d, 32'h80);
    bus_w(A_CLR, 32'h80);
    bus_r(A_PEND, d); chk("R2 clear write", d, 32'h0);
    chk("R2 nirq after clear", 32'(nirq), 32'd1);
    bus_w(A_EN_CLR, '1);

    // R9 protect mode
    bus_w(A_CFG_BASE+10, 4); bus_w(A_VEC_BASE+10, 32'hA00);
    bus_w(A_EN_SET, 32'h400); bus_w(A_CTRL, 1);
    set_src(32'h400); idle(3);
    bus_r(A_VECTOR, d); chk("R9 read1", d, 32'hA00);
    bus_r(A_VECTOR, d); chk("R9 read2", d, 32'hA00);
    chk("R9 no commit on read", 32'(nirq), 32'd0);
    bus_w(A_VECTOR, 0); idle(1);
    chk("R9 write commits", 32'(nirq), 32'd1);
    bus_w(A_EOI, 0); idle(1);
    chk("R7 pop", 32'(nirq), 32'd0);
    bus_w(A_EOI, 0); idle(1);
    chk("R7 empty pop ignored", 32'(nirq), 32'd0);
    bus_w(A_CTRL, 0);
    bus_r(A_VECTOR, d); chk("R6 normal commit vec", d, 32'hA00);
    chk("R7 single level after empty pop", 32'(nirq), 32'd1);
    bus_w(A_EOI, 0);
    set_src(0); bus_w(A_EN_CLR, '1); idle(2);

    // R10 fast line and forcing
    bus_w(A_EN_SET, 32'h1); set_src(32'h1); idle(3);
    chk("R10 src0 fiq", 32'(nfiq), 32'd0);
    chk("R10 src0 not irq", 32'(nirq), 32'd1);
    set_src(0); idle(3);
    chk("R10 fiq released", 32'(nfiq), 32'd1);
    bus_w(A_CFG_BASE+12, 6); bus_w(A_VEC_BASE+12, 32'hC00);
    bus_w(A_EN_SET, 32'h1000); bus_w(A_FORCE, 32'h1000);
    set_src(32'h1000); idle(3);
    chk("R10 forced fiq", 32'(nfiq), 32'd0);
    chk("R10 forced not irq", 32'(nirq), 32'd1);
    bus_w(A_FORCE, 0); idle(1);
    chk("R10 unforced irq", 32'(nirq), 32'd0);
    chk("R10 unforced fiq", 32'(nfiq), 32'd1);
    bus_r(A_VECTOR, d); chk("R4 unforced vec", d, 32'hC00);
    bus_w(A_EOI, 0);
    set_src(0); bus_w(A_EN_CLR, '1); idle(2);

    // R8 eight-deep nesting
    for (int k = 1; k <= 8; k++) begin
      bus_w(A_CFG_BASE+k, k-1); bus_w(A_VEC_BASE+k, 32'(k*16));
    end
    for (int k = 1; k <= 8; k++) begin
      bus_w(A_EN_SET, 32'(1) << k);
      set_src(src | (32'(1) << k)); idle(3);
      chk("R8 nest request", 32'(nirq), 32'd0);
      bus_r(A_VECTOR, d); chk("R8 nest vec", d, 32'(k*16));
      chk("R8 nest masked", 32'(nirq), 32'd1);
    end
    bus_r(A_VECTOR, d); chk("R8 full spurious", d, spur_val);
    set_src(32'h2); idle(3);
    for (int k = 0; k < 7; k++) begin
      bus_w(A_EOI, 0); idle(1);
      chk("R8 unwind", 32'(nirq), 32'd1);
    end
    bus_w(A_EOI, 0); idle(1);
    chk("R7 bottom restored", 32'(nirq), 32'd0);
    set_src(0); bus_w(A_EN_CLR, '1); idle(2);

    // constrained random against the model (level sources only)
    bsp = 0;
    for (int t = 0; t < 40; t++) begin
      for (int i = 1; i < 32; i++) begin
        m_prio[i] = int'($urandom % 8);
        m_vec[i]  = $urandom;
        bus_w(A_CFG_BASE+i, 32'(m_prio[i]));
        bus_w(A_VEC_BASE+i, m_vec[i]);
      end
      m_en = $urandom & 32'hFFFF_FFFE;
      bus_w(A_EN_CLR, '1); bus_w(A_EN_SET, m_en);
      m_src = $urandom & 32'hFFFF_FFFE;
      set_src(m_src); idle(3);
      chk("R3 random", 32'(nirq), 32'(!m_req()));
      for (int k = 0; k < 9; k++) begin
        int b;
        bit r;
        b = m_best();
        r = m_req();
        bus_r(A_VECTOR, d);
        chk("R4 random vec", d, r ? m_vec[b] : spur_val);
        if (!r) break;
        bstk[bsp] = m_prio[b];
        bsp++;
        chk("R6 random level", 32'(nirq), 32'(!m_req()));
      end
      while (bsp > 0) begin
        bus_w(A_EOI, 0);
        bsp--;
        idle(1);
        chk("R7 random pop", 32'(nirq), 32'(!m_req()));
      end
      bus_w(A_EOI, 0); idle(1);
      chk("R7 random extra pop", 32'(nirq), 32'(!m_req()));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule